// File: doc/BRIEF.md
# Condition Code Register Controller

This block keeps the eight-bit processor status word and enforces the rules that govern it. Five arithmetic flags (half carry, negative, zero, overflow, carry) are refreshed by the ALU one flag at a time under individual enables. Two interrupt masks gate the non-maskable and maskable request lines. A stop-disable bit decides whether a decoded STOP instruction halts the oscillator or falls through as a no-operation. Software may overwrite the whole word, except that the non-maskable mask, once cleared, cannot be set again by a write.

The interrupt sequencer reads the two accept outputs. After it has pushed the register onto the stack it pulses a stacking-complete strobe. The controller then raises the relevant masks on the following edge, so the stacked copy still carries the pre-interrupt masks and the vector fetch already sees the new ones. Every pin is a plain control or status signal: there is no streaming data path, so there is no valid/ready handshake and no back-pressure.

Bit layout, MSB to LSB: stop-disable (7), non-maskable mask (6), half carry (5), maskable mask (4), negative (3), zero (2), overflow (1), carry (0).

Top module: `ccr_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `ccr_q` reads 0xD0: stop-disable, non-maskable mask and maskable mask are 1, and all five flags are 0.
- R2: For `alu_flag_en`/`alu_flag_val`, index 4 maps to bit 5 (H), index 3 to bit 3 (N), index 2 to bit 2 (Z), index 1 to bit 1 (V) and index 0 to bit 0 (C). On the next edge each enabled flag takes its value, and every bit whose enable is low keeps its value.
- R3: In a cycle with no enable, no software write and no stacking-complete strobe, `ccr_q` is unchanged on the next cycle.
- R4: `sw_wr_en` loads `sw_wr_data` into every bit except bit 6 on the next edge. In the same cycle a software write takes precedence over ALU flag updates.
- R5: A software write may clear bit 6 from 1 to 0. When bit 6 is 0, a written 1 is ignored. Bit 6 then stays 0 until reset or a non-maskable entry.
- R6: `nmi_take` is high only when `nmi_pend` is high, bit 6 is 0 and no entry is in progress.
- R7: `irq_take` is high only when `irq_pend` is high, bit 4 is 0, no entry is in progress and `nmi_take` is low. When both requests are pending, the non-maskable one wins.
- R8: After `nmi_take`, the masks keep their old values until `stack_done` is sampled. On that edge bits 6 and 4 both become 1.
- R9: After `irq_take`, `stack_done` sets bit 4 only. Bit 6 is not altered by maskable entry.
- R10: When `stop_dec` is high and bit 7 is 1, `stop_as_nop` is 1 and `osc_stop_req` is 0. When `stop_dec` is high and bit 7 is 0, `osc_stop_req` is 1 and `stop_as_nop` is 0. When `stop_dec` is low, both are 0.
- R11: The mask setting at `stack_done` overrides a software write in the same cycle.
- R12: From the cycle after an accept until `stack_done` is sampled, neither accept output rises. A `stack_done` with no entry in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alu_flag_en | input | 5 | Per-flag update enables (H,N,Z,V,C from index 4 down) |
| alu_flag_val | input | 5 | New flag values, same indexing |
| sw_wr_en | input | 1 | Software write of the whole word |
| sw_wr_data | input | 8 | Value written by software |
| nmi_pend | input | 1 | Non-maskable request pending |
| irq_pend | input | 1 | Maskable request pending |
| stack_done | input | 1 | Sequencer strobe: register stacking complete |
| stop_dec | input | 1 | STOP instruction decoded |
| ccr_q | output | 8 | Current register value |
| nmi_take | output | 1 | Non-maskable request accepted |
| irq_take | output | 1 | Maskable request accepted |
| osc_stop_req | output | 1 | Request to halt the oscillator |
| stop_as_nop | output | 1 | STOP is treated as a no-operation |

## Verification
The hardest state to reach from the ports is the one where the non-maskable mask is raised again after software has cleared it. A write cannot do it, so the only route is a complete non-maskable entry. The stimulus first clears every mask with a write. It then raises both request lines together and holds them through the entry, with a clearing write in the very cycle of `stack_done`. This checks priority, suppression of further accepts during the entry, the unchanged masks before stacking ends, and the precedence of the mask setting over the write, all in one pass.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int CCR_W  = 8;
  localparam int NFLAG  = 5;
  localparam int B_S    = 7;
  localparam int B_X    = 6;
  localparam int B_H    = 5;
  localparam int B_I    = 4;
  localparam int B_N    = 3;
  localparam int B_Z    = 2;
  localparam int B_V    = 1;
  localparam int B_C    = 0;
  localparam logic [CCR_W-1:0] CCR_RST = 8'hD0;

  typedef enum logic [1:0] {ENT_IDLE = 2'd0, ENT_NMI = 2'd1, ENT_IRQ = 2'd2} ent_e;

  // Position of ALU flag index k inside the status word.
  function automatic int flag_pos(input int k);
    case (k)
      4:       return B_H;
      3:       return B_N;
      2:       return B_Z;
      1:       return B_V;
      default: return B_C;
    endcase
  endfunction
endpackage

// File: rtl/ccr_flag_merge.sv
module ccr_flag_merge
  import ccr_pkg::*;
#(
  parameter int W  = CCR_W,
  parameter int NF = NFLAG
) (
  input  logic [W-1:0]  cur,
  input  logic [NF-1:0] fen,
  input  logic [NF-1:0] fval,
  output logic [W-1:0]  merged
);
  logic [W-1:0] en_mask;
  logic [W-1:0] val_mask;

  always_comb begin
    en_mask  = '0;
    val_mask = '0;
    for (int k = 0; k < NF; k++) begin
      en_mask[flag_pos(k)]  = fen[k];
      val_mask[flag_pos(k)] = fval[k];
    end
  end

  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      assign merged[b] = en_mask[b] ? val_mask[b] : cur[b];
    end
  endgenerate
endmodule

// File: rtl/ccr_entry_seq.sv
module ccr_entry_seq
  import ccr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_pend,
  input  logic irq_pend,
  input  logic x_mask,
  input  logic i_mask,
  input  logic stack_done,
  output logic nmi_take,
  output logic irq_take,
  output logic set_x,
  output logic set_i
);
  ent_e state_q, state_d;

  always_comb begin
    nmi_take = (state_q == ENT_IDLE) && nmi_pend && !x_mask;
    irq_take = (state_q == ENT_IDLE) && irq_pend && !i_mask && !nmi_take;
    set_x    = stack_done && (state_q == ENT_NMI);
    set_i    = stack_done && (state_q != ENT_IDLE);
    state_d  = state_q;
    if (state_q != ENT_IDLE) begin
      if (stack_done) state_d = ENT_IDLE;
    end else if (nmi_take) begin
      state_d = ENT_NMI;
    end else if (irq_take) begin
      state_d = ENT_IRQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ENT_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/ccr_stop_gate.sv
module ccr_stop_gate (
  input  logic stop_dec,
  input  logic stop_dis,
  output logic osc_stop_req,
  output logic stop_as_nop
);
  assign osc_stop_req = stop_dec && !stop_dis;
  assign stop_as_nop  = stop_dec && stop_dis;
endmodule

// File: rtl/ccr_ctrl.sv
module ccr_ctrl
  import ccr_pkg::*;
#(
  parameter int W  = CCR_W,
  parameter int NF = NFLAG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] alu_flag_en,
  input  logic [NF-1:0] alu_flag_val,
  input  logic          sw_wr_en,
  input  logic [W-1:0]  sw_wr_data,
  input  logic          nmi_pend,
  input  logic          irq_pend,
  input  logic          stack_done,
  input  logic          stop_dec,
  output logic [W-1:0]  ccr_q,
  output logic          nmi_take,
  output logic          irq_take,
  output logic          osc_stop_req,
  output logic          stop_as_nop
);
  logic [W-1:0] ccr_r, ccr_alu, ccr_d;
  logic         set_x, set_i;

  ccr_flag_merge #(.W(W), .NF(NF)) u_merge (
    .cur(ccr_r), .fen(alu_flag_en), .fval(alu_flag_val), .merged(ccr_alu)
  );

  ccr_entry_seq u_seq (
    .clk(clk), .rst_n(rst_n), .nmi_pend(nmi_pend), .irq_pend(irq_pend),
    .x_mask(ccr_r[B_X]), .i_mask(ccr_r[B_I]), .stack_done(stack_done),
    .nmi_take(nmi_take), .irq_take(irq_take), .set_x(set_x), .set_i(set_i)
  );

  ccr_stop_gate u_stop (
    .stop_dec(stop_dec), .stop_dis(ccr_r[B_S]),
    .osc_stop_req(osc_stop_req), .stop_as_nop(stop_as_nop)
  );

  // Priority: mask setting > software write > ALU flags.
  always_comb begin
    ccr_d = ccr_alu;
    if (sw_wr_en) begin
      ccr_d      = sw_wr_data;
      ccr_d[B_X] = ccr_r[B_X] & sw_wr_data[B_X];
    end
    if (set_x) ccr_d[B_X] = 1'b1;
    if (set_i) ccr_d[B_I] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ccr_r <= CCR_RST;
    else        ccr_r <= ccr_d;
  end

  assign ccr_q = ccr_r;
endmodule

// File: rtl/ccr_ctrl_chk.sv
module ccr_ctrl_chk
  import ccr_pkg::*;
#(
  parameter int W  = CCR_W,
  parameter int NF = NFLAG
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NF-1:0] alu_flag_en,
  input logic          sw_wr_en,
  input logic          nmi_pend,
  input logic          irq_pend,
  input logic          stack_done,
  input logic          stop_dec,
  input logic [W-1:0]  ccr_q,
  input logic          nmi_take,
  input logic          irq_take,
  input logic          osc_stop_req,
  input logic          stop_as_nop
);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr_en && alu_flag_en == '0 && !stack_done) |=> $stable(ccr_q));
  a_r5_x_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ccr_q[B_X]) |-> $past(stack_done));
  a_r8_both_masks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ccr_q[B_X]) |-> ccr_q[B_I]);
  a_r6_nmi_gate: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_take |-> (nmi_pend && !ccr_q[B_X]));
  a_r7_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (irq_pend && !ccr_q[B_I] && !nmi_take));
  a_r12_one_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_take || irq_take) |=> !(nmi_take || irq_take));
  a_r10_stop_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(osc_stop_req && stop_as_nop));
  a_r10_stop_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_dec && ccr_q[B_S]) |-> stop_as_nop);
endmodule

bind ccr_ctrl ccr_ctrl_chk #(.W(W), .NF(NF)) u_chk (
  .clk(clk), .rst_n(rst_n), .alu_flag_en(alu_flag_en), .sw_wr_en(sw_wr_en),
  .nmi_pend(nmi_pend), .irq_pend(irq_pend), .stack_done(stack_done),
  .stop_dec(stop_dec), .ccr_q(ccr_q), .nmi_take(nmi_take), .irq_take(irq_take),
  .osc_stop_req(osc_stop_req), .stop_as_nop(stop_as_nop)
);

// File: tb/sim_ccr_ctrl.sv
`timescale 1ns/1ps
module sim_ccr_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] fen = '0, fval = '0;
  logic       swe = 1'b0;
  logic [7:0] swd = '0;
  logic       nmi = 1'b0, irq = 1'b0, sd = 1'b0, stp = 1'b0;
  logic [7:0] ccr;
  logic       nt, it, osr, nop;

  always #4 clk = ~clk;

  ccr_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .alu_flag_en(fen), .alu_flag_val(fval),
    .sw_wr_en(swe), .sw_wr_data(swd), .nmi_pend(nmi), .irq_pend(irq),
    .stack_done(sd), .stop_dec(stp), .ccr_q(ccr), .nmi_take(nt),
    .irq_take(it), .osc_stop_req(osr), .stop_as_nop(nop)
  );

  typedef struct {
    logic [7:0] ccr;
    logic [3:0] outs;
    string      tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0, n_bad = 0;
  logic [7:0] m = 8'hD0;
  int mst = 0;  // 0 idle, 1 nmi entry, 2 irq entry
  int fpos[5] = '{0, 1, 2, 3, 5};  // index k -> bit (C,V,Z,N,H)

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual ccr=%h outs=%b expected ccr=%h outs=%b",
               tag, act[11:4], act[3:0], exp[11:4], exp[3:0]);
    end
  endtask

  // Driver: one cycle of stimulus, expected outputs pushed to the scoreboard.
  task automatic cyc(input logic e, input logic [7:0] d, input logic [4:0] fe,
                     input logic [4:0] fv, input logic n, input logic i,
                     input logic s, input logic st, input string tag);
    exp_t x;
    logic en, ei;
    logic [7:0] nx;
    @(negedge clk);
    swe = e; swd = d; fen = fe; fval = fv; nmi = n; irq = i; sd = s; stp = st;
    en = n && !m[6] && mst == 0;
    ei = i && !m[4] && mst == 0 && !en;
    x.ccr = m;
    x.outs = {en, ei, st && !m[7], st && m[7]};
    x.tag = tag;
    q.push_back(x);
    nx = m;
    for (int k = 0; k < 5; k++) if (fe[k]) nx[fpos[k]] = fv[k];
    if (e) begin nx = d; nx[6] = m[6] & d[6]; end
    if (s && mst == 1) begin nx[6] = 1'b1; nx[4] = 1'b1; mst = 0; end
    else if (s && mst == 2) begin nx[4] = 1'b1; mst = 0; end
    else if (en) mst = 1;
    else if (ei) mst = 2;
    m = nx;
  endtask

  // Monitor: pops and compares mid-cycle.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t x;
        x = q.pop_front();
        check(x.tag, {ccr, nt, it, osr, nop}, {x.ccr, x.outs});
      end
    end
  end

  initial begin
    #(8 * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2 check("R1 in reset", {ccr, nt, it, osr, nop}, {8'hD0, 4'b0000});
    @(negedge clk); rst_n = 1'b1;
    cyc(0, 8'h00, 5'h00, 5'h00, 0, 0, 0, 0, "R1 after reset");
    cyc(0, 8'h00, 5'h00, 5'h00, 0, 0, 0, 0, "R3 idle hold");
    cyc(0, 8'h00, 5'b01001, 5'b11111, 0, 0, 0, 0, "R2 N and C enabled");
    cyc(0, 8'h00, 5'h00, 5'h1F, 0, 0, 0, 0, "R3 values without enables");
    cyc(0, 8'h00, 5'h1F, 5'b10100, 0, 0, 0, 0, "R2 all enabled");
    cyc(0, 8'h00, 5'h00, 5'h00, 1, 1, 0, 0, "R6 R7 masked requests");
    cyc(0, 8'h00, 5'h00, 5'h00, 0, 0, 1, 0, "R12 stray stack_done");
    cyc(1, 8'h00, 5'h1F, 5'h1F, 0, 0, 0, 1, "R4 write beats ALU, R10 S=1");
    cyc(1, 8'h40, 5'h00, 5'h00, 0, 0, 0, 1, "R5 R10 S=0 stop");
    cyc(1, 8'h6A, 5'h00, 5'h00, 0, 0, 0, 0, "R5 X write 1 ignored");
    cyc(1, 8'h00, 5'h00, 5'h00, 0, 0, 0, 0, "R4 clear");
    cyc(0, 8'h00, 5'h00, 5'h00, 1, 1, 0, 0, "R7 priority nmi");
    cyc(0, 8'h00, 5'b00100, 5'b00100, 1, 1, 0, 0, "R12 R8 entry in progress");
    cyc(0, 8'h00, 5'h00, 5'h00, 1, 1, 0, 0, "R8 masks unchanged");
    cyc(1, 8'h00, 5'h00, 5'h00, 1, 1, 1, 0, "R11 R8 stack_done with write");
    cyc(0, 8'h00, 5'h00, 5'h00, 1, 1, 0, 0, "R8 R6 masks set");
    cyc(1, 8'h00, 5'h00, 5'h00, 0, 0, 0, 0, "R5 clear after entry");
    cyc(0, 8'h00, 5'h00, 5'h00, 0, 1, 0, 0, "R7 irq accepted");
    cyc(0, 8'h00, 5'h00, 5'h00, 0, 1, 0, 0, "R12 irq entry");
    cyc(0, 8'h00, 5'h00, 5'h00, 0, 1, 1, 0, "R9 irq stack_done");
    cyc(0, 8'h00, 5'h00, 5'h00, 1, 1, 0, 0, "R9 X unchanged, R6");
    cyc(0, 8'h00, 5'h00, 5'h00, 0, 1, 0, 0, "R12 nmi entry");
    cyc(0, 8'h00, 5'h00, 5'h00, 0, 0, 1, 0, "R8 nmi stack_done");
    cyc(0, 8'h00, 5'h00, 5'h00, 1, 1, 0, 1, "R6 R7 R10 all masked");
    cyc(0, 8'h00, 5'h00, 5'h00, 0, 0, 0, 0, "R3 final hold");
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule